// File: doc/BRIEF.md
# Slave-Mode EPROM Programming Sequencer

This block is the host-side controller that writes and reads back an on-chip EPROM held in its slave programming mode. It generates three active-low strobes towards the memory (an address latch strobe, a program/read strobe and an address-increment strobe), drives the shared address/data word with an output enable, and samples the word the memory dumps back plus the verify line it returns after a write. Every interval is counted in periods of the block's own clock, which is the oscillator of the memory being programmed.

A command with an address or data word is issued with a one-cycle start strobe. Three operations exist: latching an address, programming a word with verify, and dumping a word followed by an automatic address increment. A program operation first reads the cell; because erased bits read as 1 and programming can only clear bits, a word that would need any bit raised is refused without a write pulse. The long write pulse is a fixed base plus a parameter that holds the 100 us term expressed in clock periods.

Top module: `eprom_slave_prog`

## Requirements
- R1: In reset all strobes are high, wbus_oe_o, vfail_o, bad_word_o and dump_o are 0 and busy_o is 1; busy_o stays 1 for T_BOOT cycles after reset release, starts are ignored meanwhile, and the first address strobe falls no earlier than T_BOOT cycles after release.
- R2: cmd_i=0 (latch): on the edge after acceptance alat_no goes low for exactly T_ALAT cycles while wbus_o carries addr_i with wbus_oe_o=1; busy_o stays high for T_ALAT plus max(T_GAP, T_AHOLD-T_ALAT) cycles in total.
- R3: cmd_i=2 (dump): wbus_oe_o drops and pstb_no is low for T_DUMP cycles; rbus_i is captured into dump_o at the edge where pstb_no rises, incr_no is low for T_INCR cycles starting at that edge, and busy_o ends max(T_INCR_GAP, T_GAP-T_INCR) cycles after incr_no rises.
- R4: cmd_i=1 (program): a T_DUMP read pulse with wbus_oe_o=0, then T_GAP idle cycles, then data_i is driven with wbus_oe_o=1 and pstb_no is low for max(T_PGM_BASE+T_PGM_EXTRA, T_DHOLD) cycles with wbus_o stable; T_GAP cycles after pstb_no rises vok_i is sampled and vfail_o set to its inverse.
- R5: If the word read during a program operation has a 0 where data_i has a 1, no write pulse is issued, bad_word_o becomes 1 and busy_o drops at the end of the T_GAP cycles after the read pulse; a data word equal to the read word is written normally.
- R6: A start while busy_o is 1, and a start with cmd_i=3, are ignored; no strobe moves while busy_o is 0.
- R7: From any rise of alat_no or pstb_no to the next fall of either, at least T_GAP cycles pass; the three strobes are never low together in pairs.
- R8: A program operation clears vfail_o and bad_word_o on acceptance and leaves dump_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock; all intervals count its periods |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle command strobe |
| cmd_i | input | 2 | 0 latch, 1 program, 2 dump, 3 none |
| addr_i | input | DW | Address for the latch command |
| data_i | input | DW | Word for the program command |
| busy_o | output | 1 | Operation or power-up wait in progress |
| vfail_o | output | 1 | Last program verify failed |
| bad_word_o | output | 1 | Last program refused: a bit would need raising |
| dump_o | output | DW | Word captured by the last dump |
| alat_no | output | 1 | Address latch strobe, active low |
| pstb_no | output | 1 | Program/read strobe, active low |
| incr_no | output | 1 | Address increment strobe, active low |
| wbus_o | output | DW | Address/data word towards the memory |
| wbus_oe_o | output | 1 | Drive enable for wbus_o |
| rbus_i | input | DW | Word returned by the memory |
| vok_i | input | 1 | Verify line from the memory, high on success |

## Verification
A phase counter loaded with a wrong length or a phase decoded to the wrong strobe shows as a strobe edge or a busy edge off by at least one cycle, which the per-cycle comparison against the behavioural model catches on that very cycle. A wrong captured read word or a wrong refusal decision stays hidden until the end of the gap after the read pulse, where it shows as a missing or spurious write pulse and bad_word_o flag. A wrong verify capture appears only at busy release, T_GAP cycles after the write pulse ends.

// File: rtl/eprom_sp_pkg.sv
package eprom_sp_pkg;

  typedef enum logic [1:0] {
    CMD_LATCH = 2'd0,
    CMD_PGM   = 2'd1,
    CMD_DUMP  = 2'd2,
    CMD_NOP   = 2'd3
  } sp_cmd_e;

  typedef enum logic [3:0] {
    PH_BOOT, PH_IDLE, PH_ALAT, PH_ATAIL, PH_RD, PH_RDGAP,
    PH_PGM, PH_PTAIL, PH_DUMP, PH_INCR, PH_ITAIL
  } sp_phase_e;

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned usub1(input int unsigned a, input int unsigned b);
    return (a > b) ? a - b : 1;
  endfunction

endpackage

// File: rtl/sp_phase_timer.sv
module sp_phase_timer #(
  parameter int unsigned CW       = 12,
  parameter int unsigned BOOT_LEN = 1100
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] len_i,
  output logic          done_o
);
  logic [CW-1:0] cnt_q;

  // phase of length L occupies exactly L cycles: load L-1, end at 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= CW'(BOOT_LEN - 1);
    else if (load_i)          cnt_q <= len_i - 1'b1;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/sp_seq_fsm.sv
module sp_seq_fsm
  import eprom_sp_pkg::*;
#(
  parameter int unsigned CW      = 12,
  parameter int unsigned L_ALAT  = 50,
  parameter int unsigned L_ATAIL = 220,
  parameter int unsigned L_GAP   = 220,
  parameter int unsigned L_DUMP  = 50,
  parameter int unsigned L_PGM   = 1900,
  parameter int unsigned L_INCR  = 240,
  parameter int unsigned L_ITAIL = 170
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [1:0]    cmd_i,
  input  logic          tmr_done_i,
  input  logic          word_bad_i,
  output logic          load_o,
  output logic [CW-1:0] len_o,
  output logic          go_lat_o,
  output logic          go_pgm_o,
  output logic          go_dmp_o,
  output logic          rd_end_o,
  output logic          chk_o,
  output logic          pfin_o,
  output logic          dcap_o,
  output logic          busy_o,
  output logic          alat_no,
  output logic          pstb_no,
  output logic          incr_no
);
  sp_phase_e ph_q, ph_d;
  sp_cmd_e   cmd;
  logic      accept;

  assign cmd    = sp_cmd_e'(cmd_i);
  assign accept = (ph_q == PH_IDLE) && start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= PH_BOOT;
    else         ph_q <= ph_d;
  end

  always_comb begin
    ph_d   = ph_q;
    load_o = 1'b0;
    len_o  = '0;
    case (ph_q)
      PH_BOOT:  if (tmr_done_i) ph_d = PH_IDLE;
      PH_IDLE: if (start_i) begin
        case (cmd)
          CMD_LATCH: begin ph_d = PH_ALAT; load_o = 1'b1; len_o = CW'(L_ALAT); end
          CMD_PGM:   begin ph_d = PH_RD;   load_o = 1'b1; len_o = CW'(L_DUMP); end
          CMD_DUMP:  begin ph_d = PH_DUMP; load_o = 1'b1; len_o = CW'(L_DUMP); end
          default:   ph_d = PH_IDLE;
        endcase
      end
      PH_ALAT:  if (tmr_done_i) begin ph_d = PH_ATAIL; load_o = 1'b1; len_o = CW'(L_ATAIL); end
      PH_ATAIL: if (tmr_done_i) ph_d = PH_IDLE;
      PH_RD:    if (tmr_done_i) begin ph_d = PH_RDGAP; load_o = 1'b1; len_o = CW'(L_GAP); end
      PH_RDGAP: if (tmr_done_i) begin
        if (word_bad_i) ph_d = PH_IDLE;
        else begin ph_d = PH_PGM; load_o = 1'b1; len_o = CW'(L_PGM); end
      end
      PH_PGM:   if (tmr_done_i) begin ph_d = PH_PTAIL; load_o = 1'b1; len_o = CW'(L_GAP); end
      PH_PTAIL: if (tmr_done_i) ph_d = PH_IDLE;
      PH_DUMP:  if (tmr_done_i) begin ph_d = PH_INCR; load_o = 1'b1; len_o = CW'(L_INCR); end
      PH_INCR:  if (tmr_done_i) begin ph_d = PH_ITAIL; load_o = 1'b1; len_o = CW'(L_ITAIL); end
      PH_ITAIL: if (tmr_done_i) ph_d = PH_IDLE;
      default:  ph_d = PH_IDLE;
    endcase
  end

  assign go_lat_o = accept && (cmd == CMD_LATCH);
  assign go_pgm_o = accept && (cmd == CMD_PGM);
  assign go_dmp_o = accept && (cmd == CMD_DUMP);
  assign rd_end_o = (ph_q == PH_RD)    && tmr_done_i;
  assign chk_o    = (ph_q == PH_RDGAP) && tmr_done_i;
  assign pfin_o   = (ph_q == PH_PTAIL) && tmr_done_i;
  assign dcap_o   = (ph_q == PH_DUMP)  && tmr_done_i;

  assign busy_o  = (ph_q != PH_IDLE);
  assign alat_no = (ph_q != PH_ALAT);
  assign pstb_no = !((ph_q == PH_RD) || (ph_q == PH_PGM) || (ph_q == PH_DUMP));
  assign incr_no = (ph_q != PH_INCR);
endmodule

// File: rtl/sp_word_path.sv
module sp_word_path #(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_lat_i,
  input  logic          go_pgm_i,
  input  logic          go_dmp_i,
  input  logic          rd_end_i,
  input  logic          chk_i,
  input  logic          pfin_i,
  input  logic          dcap_i,
  input  logic [DW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic [DW-1:0] rbus_i,
  input  logic          vok_i,
  output logic [DW-1:0] wbus_o,
  output logic          wbus_oe_o,
  output logic [DW-1:0] dump_o,
  output logic          vfail_o,
  output logic          bad_o,
  output logic          word_bad_o
);
  logic [DW-1:0] want_q, cur_q;

  // a 1 requested over a programmed 0 cannot be written
  assign word_bad_o = |(want_q & ~cur_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbus_o    <= '0;
      wbus_oe_o <= 1'b0;
      want_q    <= '0;
      cur_q     <= '0;
      dump_o    <= '0;
      vfail_o   <= 1'b0;
      bad_o     <= 1'b0;
    end else begin
      if (go_lat_i) begin
        wbus_o    <= addr_i;
        wbus_oe_o <= 1'b1;
      end
      if (go_pgm_i) begin
        want_q    <= data_i;
        wbus_oe_o <= 1'b0;
        vfail_o   <= 1'b0;
        bad_o     <= 1'b0;
      end
      if (go_dmp_i) wbus_oe_o <= 1'b0;
      if (rd_end_i) cur_q <= rbus_i;
      if (chk_i) begin
        if (word_bad_o) bad_o <= 1'b1;
        else begin
          wbus_o    <= want_q;
          wbus_oe_o <= 1'b1;
        end
      end
      if (pfin_i) vfail_o <= !vok_i;
      if (dcap_i) dump_o  <= rbus_i;
    end
  end
endmodule

// File: rtl/eprom_slave_prog.sv
module eprom_slave_prog
  import eprom_sp_pkg::*;
#(
  parameter int unsigned DW          = 16,
  parameter int unsigned T_BOOT      = 1100,
  parameter int unsigned T_ALAT      = 50,
  parameter int unsigned T_AHOLD     = 100,
  parameter int unsigned T_GAP       = 220,
  parameter int unsigned T_DUMP      = 50,
  parameter int unsigned T_PGM_BASE  = 300,
  parameter int unsigned T_PGM_EXTRA = 1600,
  parameter int unsigned T_DHOLD     = 400,
  parameter int unsigned T_INCR      = 240,
  parameter int unsigned T_INCR_GAP  = 170
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [1:0]    cmd_i,
  input  logic [DW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          busy_o,
  output logic          vfail_o,
  output logic          bad_word_o,
  output logic [DW-1:0] dump_o,
  output logic          alat_no,
  output logic          pstb_no,
  output logic          incr_no,
  output logic [DW-1:0] wbus_o,
  output logic          wbus_oe_o,
  input  logic [DW-1:0] rbus_i,
  input  logic          vok_i
);
  localparam int unsigned L_ATAIL = umax(T_GAP, usub1(T_AHOLD, T_ALAT));
  localparam int unsigned L_PGM   = umax(T_PGM_BASE + T_PGM_EXTRA, T_DHOLD);
  localparam int unsigned L_ITAIL = umax(T_INCR_GAP, usub1(T_GAP, T_INCR));
  localparam int unsigned L_MAX   = umax(umax(umax(T_BOOT, L_PGM), umax(L_ATAIL, T_GAP)),
                                         umax(umax(T_ALAT, T_DUMP), umax(T_INCR, L_ITAIL)));
  localparam int unsigned CW      = $clog2(L_MAX + 1);

  logic          load, done, word_bad;
  logic [CW-1:0] len;
  logic          go_lat, go_pgm, go_dmp, rd_end, chk, pfin, dcap;

  sp_phase_timer #(.CW(CW), .BOOT_LEN(T_BOOT)) i_timer (
    .clk_i, .rst_ni, .load_i(load), .len_i(len), .done_o(done)
  );

  sp_seq_fsm #(
    .CW(CW), .L_ALAT(T_ALAT), .L_ATAIL(L_ATAIL), .L_GAP(T_GAP), .L_DUMP(T_DUMP),
    .L_PGM(L_PGM), .L_INCR(T_INCR), .L_ITAIL(L_ITAIL)
  ) i_fsm (
    .clk_i, .rst_ni, .start_i, .cmd_i,
    .tmr_done_i(done), .word_bad_i(word_bad),
    .load_o(load), .len_o(len),
    .go_lat_o(go_lat), .go_pgm_o(go_pgm), .go_dmp_o(go_dmp),
    .rd_end_o(rd_end), .chk_o(chk), .pfin_o(pfin), .dcap_o(dcap),
    .busy_o, .alat_no, .pstb_no, .incr_no
  );

  sp_word_path #(.DW(DW)) i_path (
    .clk_i, .rst_ni,
    .go_lat_i(go_lat), .go_pgm_i(go_pgm), .go_dmp_i(go_dmp),
    .rd_end_i(rd_end), .chk_i(chk), .pfin_i(pfin), .dcap_i(dcap),
    .addr_i, .data_i, .rbus_i, .vok_i,
    .wbus_o, .wbus_oe_o, .dump_o, .vfail_o,
    .bad_o(bad_word_o), .word_bad_o(word_bad)
  );
endmodule

// File: rtl/sp_prog_checker.sv
module sp_prog_checker #(
  parameter int unsigned DW     = 16,
  parameter int unsigned T_BOOT = 1100,
  parameter int unsigned T_ALAT = 50,
  parameter int unsigned T_GAP  = 220
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_o,
  input logic          bad_word_o,
  input logic          alat_no,
  input logic          pstb_no,
  input logic          incr_no,
  input logic [DW-1:0] wbus_o,
  input logic          wbus_oe_o
);
  int unsigned boot_cnt, lo_cnt, quiet_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      boot_cnt  <= 0;
      lo_cnt    <= 0;
      quiet_cnt <= T_GAP;
    end else begin
      if (boot_cnt < T_BOOT) boot_cnt <= boot_cnt + 1;
      lo_cnt <= alat_no ? 0 : lo_cnt + 1;
      if (!alat_no || !pstb_no)   quiet_cnt <= 0;
      else if (quiet_cnt < T_GAP) quiet_cnt <= quiet_cnt + 1;
    end
  end

  AST_BOOT_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(alat_no) |-> boot_cnt >= T_BOOT); // R1
  AST_ALAT_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alat_no) |-> lo_cnt == T_ALAT); // R2
  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({!alat_no, !pstb_no, !incr_no})); // R7
  AST_STROBE_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(alat_no) || $fell(pstb_no)) |-> quiet_cnt >= T_GAP); // R7
  AST_WDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pstb_no && wbus_oe_o && $past(!pstb_no && wbus_oe_o)) |-> $stable(wbus_o)); // R4
  AST_BAD_NO_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bad_word_o) |-> (pstb_no && !busy_o)); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (alat_no && pstb_no && incr_no)); // R6
endmodule

bind eprom_slave_prog sp_prog_checker #(
  .DW(DW), .T_BOOT(T_BOOT), .T_ALAT(T_ALAT), .T_GAP(T_GAP)
) i_sp_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .bad_word_o(bad_word_o),
  .alat_no(alat_no), .pstb_no(pstb_no), .incr_no(incr_no),
  .wbus_o(wbus_o), .wbus_oe_o(wbus_oe_o)
);

// File: tb/test_eprom_slave_prog.sv
`timescale 1ns/1ps
module test_eprom_slave_prog;
  localparam int T_BOOT = 1100, T_ALAT = 50, T_GAP = 220, T_DUMP = 50;
  localparam int T_INCR = 240;
  localparam int L_ATAIL = 220;   // larger of gap and address hold remainder
  localparam int L_PGM   = 1900;  // 300 base + 1600 (100 us at 16 MHz)
  localparam int L_ITAIL = 170;

  logic clk = 0, rst_n = 0, start = 0, vok = 1;
  logic [1:0]  cmd = 0;
  logic [15:0] addr = 0, data = 0, rbus = 16'hFFFF;
  logic busy, vfail, bad, alat_n, pstb_n, incr_n, oe;
  logic [15:0] dump, wbus;

  always #2.5 clk = ~clk;

  eprom_slave_prog i_eprom_slave_prog (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cmd_i(cmd), .addr_i(addr), .data_i(data),
    .busy_o(busy), .vfail_o(vfail), .bad_word_o(bad), .dump_o(dump),
    .alat_no(alat_n), .pstb_no(pstb_n), .incr_no(incr_n),
    .wbus_o(wbus), .wbus_oe_o(oe), .rbus_i(rbus), .vok_i(vok)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0, en = 0;

  task automatic cmp(input string tag, input string nm, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, nm, act, exp);
    end
  endtask

  // behavioural reference model
  int m_boot, m_op, m_el;
  logic [15:0] m_want, m_cur, e_wbus, e_dump;
  logic e_oe, e_vf, e_bad, m_refused;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_boot = T_BOOT; m_op = -1; m_el = 0; e_wbus = 0; e_dump = 0;
      e_oe = 0; e_vf = 0; e_bad = 0; m_want = 0; m_cur = 0; m_refused = 0;
    end else if (m_boot > 0) m_boot--;
    else if (m_op < 0) begin
      if (start) begin
        case (cmd)
          2'd0: begin m_op = 0; m_el = 0; e_wbus = addr; e_oe = 1; end
          2'd1: begin m_op = 1; m_el = 0; m_want = data; e_oe = 0; e_vf = 0; e_bad = 0; m_refused = 0; end
          2'd2: begin m_op = 2; m_el = 0; e_oe = 0; end
          default: ;
        endcase
      end
    end else begin
      m_el++;
      if (m_op == 0 && m_el == T_ALAT + L_ATAIL) m_op = -1;
      else if (m_op == 2) begin
        if (m_el == T_DUMP) e_dump = rbus;
        if (m_el == T_DUMP + T_INCR + L_ITAIL) m_op = -1;
      end else if (m_op == 1) begin
        if (m_el == T_DUMP) m_cur = rbus;
        if (m_el == T_DUMP + T_GAP) begin
          if ((m_want & ~m_cur) != 0) begin e_bad = 1; m_refused = 1; m_op = -1; end
          else begin e_wbus = m_want; e_oe = 1; end
        end
        if (m_op == 1 && m_el == T_DUMP + 2 * T_GAP + L_PGM) begin e_vf = !vok; m_op = -1; end
      end
    end
  end

  function automatic logic exp_pstb_n();
    if (m_op == 2) return !(m_el < T_DUMP);
    if (m_op == 1) return !(m_el < T_DUMP ||
                            (m_el >= T_DUMP + T_GAP && m_el < T_DUMP + T_GAP + L_PGM));
    return 1'b1;
  endfunction

  int cyc = 0, last_rise = -100000, first_alat = -1;
  logic p_alat = 1, p_pstb = 1;
  always @(posedge clk) if (rst_n) cyc++;

  always @(negedge clk) begin
    if (en) begin
      cmp("R6", "busy", busy, (m_boot > 0 || m_op >= 0));
      cmp("R2", "alat", alat_n, !(m_op == 0 && m_el < T_ALAT));
      cmp("R4", "pstb", pstb_n, exp_pstb_n());
      cmp("R3", "incr", incr_n, !(m_op == 2 && m_el >= T_DUMP && m_el < T_DUMP + T_INCR));
      cmp("R2", "oe", oe, e_oe);
      cmp("R4", "wbus", wbus, e_wbus);
      cmp("R3", "dump", dump, e_dump);
      cmp("R4", "vfail", vfail, e_vf);
      cmp("R5", "bad", bad, e_bad);
      if ((p_alat && !alat_n) || (p_pstb && !pstb_n)) begin
        cmp("R7", "gap_ok", (cyc - last_rise >= T_GAP), 1);
        if (first_alat < 0 && !alat_n) begin
          first_alat = cyc;
          cmp("R1", "boot_wait_ok", (cyc >= T_BOOT), 1);
        end
      end
      if ((!p_alat && alat_n) || (!p_pstb && pstb_n)) last_rise = cyc;
      p_alat = alat_n; p_pstb = pstb_n;
    end
  end

  task automatic launch(input logic [1:0] c, input logic [15:0] a, input logic [15:0] d,
                        input logic [15:0] rb, input logic vk);
    @(negedge clk);
    cmd = c; addr = a; data = d; rbus = rb; vok = vk; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic run_op(input logic [1:0] c, input logic [15:0] a, input logic [15:0] d,
                        input logic [15:0] rb, input logic vk);
    launch(c, a, d, rb, vk);
    wait_idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    cmp("R1", "rst_strobes", {alat_n, pstb_n, incr_n}, 3'b111);
    cmp("R1", "rst_busy", busy, 1);
    cmp("R1", "rst_flags", {oe, vfail, bad}, 3'b000);
    cmp("R1", "rst_dump", dump, 0);
    rst_n = 1; en = 1;
    repeat (20) @(negedge clk);
    // R1 start during power-up wait is ignored
    launch(2'd0, 16'h7777, 16'h0, 16'hFFFF, 1);
    wait_idle();
    cmp("R1", "boot_len", cyc, T_BOOT);
    cmp("R1", "no_latch_in_boot", first_alat, -1);
    // R2 latch
    run_op(2'd0, 16'h1234, 16'h0, 16'hFFFF, 1);
    cmp("R2", "addr_on_bus", wbus, 16'h1234);
    // R3 dump
    run_op(2'd2, 16'h0, 16'h0, 16'hA5C3, 1);
    cmp("R3", "dump_word", dump, 16'hA5C3);
    // R4 program from erased, verify ok
    run_op(2'd1, 16'h0, 16'h1234, 16'hFFFF, 1);
    cmp("R4", "vfail_clear", vfail, 0);
    cmp("R8", "dump_kept", dump, 16'hA5C3);
    // R4 verify failure
    run_op(2'd1, 16'h0, 16'h00F0, 16'h00FF, 0);
    cmp("R4", "vfail_set", vfail, 1);
    // R8 flags cleared on acceptance; R5 refusal
    launch(2'd1, 16'h0, 16'h0F0F, 16'h00FF, 1);
    cmp("R8", "vfail_cleared_on_start", vfail, 0);
    wait_idle();
    cmp("R5", "refused", bad, 1);
    cmp("R5", "no_write_data", wbus, 16'h00F0);
    // R5 boundary: identical word is programmable
    run_op(2'd1, 16'h0, 16'h3C3C, 16'h3C3C, 1);
    cmp("R5", "equal_ok", bad, 0);
    cmp("R8", "dump_kept2", dump, 16'hA5C3);
    // R6 no-op command
    launch(2'd3, 16'h9999, 16'h0, 16'hFFFF, 1);
    repeat (5) @(negedge clk);
    cmp("R6", "nop_idle", busy, 0);
    cmp("R6", "nop_bus", wbus, 16'h3C3C);
    // R6 start while busy
    launch(2'd2, 16'h0, 16'h0, 16'h5A5A, 1);
    repeat (100) @(negedge clk);
    launch(2'd0, 16'hBEEF, 16'h0, 16'h5A5A, 1);
    wait_idle();
    cmp("R6", "busy_start_ignored", wbus, 16'h3C3C);
    cmp("R3", "dump_word2", dump, 16'h5A5A);
    // back to back: latch then dump immediately
    run_op(2'd0, 16'h0042, 16'h0, 16'h1111, 1);
    run_op(2'd2, 16'h0, 16'h0, 16'h0F0F, 1);
    cmp("R3", "dump_word3", dump, 16'h0F0F);
    repeat (10) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule